// File: doc/BRIEF.md
# Parallel Polyphase FIR Interpolator

This block raises the sample rate of a signed stream by an integer factor M. It does so without a clock at the higher rate. It takes at most one input sample per clock and returns M output samples on the same clock, side by side on M lanes. Each lane evaluates one polyphase branch of a low-pass prototype FIR. The branches never see the zeros that plain zero-stuffing would insert, so no multiplier is ever spent on them.

All lanes read one shared delay line of accepted input samples. Lane k applies the prototype taps k, k+M, k+2M and so on. The lanes are ordered in time, so a downstream serialiser that sends lane 0 first and lane M-1 last recreates the upsampled stream. Coefficients are a design parameter, packed with tap 0 in the lowest bits. A prototype whose length is not a multiple of M is padded with zero taps, and those taps build no hardware.

Each lane sums its products at full precision. It then adds half an output step, shifts right arithmetically by a parameterised amount and clamps the result to the output width. The reset input is asynchronous and active low. Its release is synchronised inside the block before it reaches any state.

Top module: `polyphase_interp`

## Requirements
- R1: During reset and after its release, out_valid is 0 and every lane of out_data is 0 until the first accepted sample has reached the output.
- R2: A sample accepted at a rising edge with in_valid high produces out_valid high after the second rising edge that follows it. Otherwise out_valid is low.
- R3: For the n-th accepted sample, lane k (bits k*DOUT_W and up, signed) carries the rounded value of the sum over j of h[k+j*M] times x[n-j]. Here x counts accepted samples only, h[i] is the coefficient at bits i*COEF_W and up, and x before the first sample is 0. Lane 0 is the earliest output in time.
- R4: A cycle with in_valid low moves no sample through the delay line and leaves every lane of out_data unchanged.
- R5: Taps at indices NTAPS and above count as zero. With an impulse of amplitude A, lane k on the j-th output after it shows the rounded A*h[k+j*M], and it shows 0 where k+j*M >= NTAPS.
- R6: Rounding adds 2^(SHIFT-1) to the full-precision sum and then shifts right arithmetically by SHIFT, so an exact half rounds toward plus infinity.
- R7: A rounded value above 2^(DOUT_W-1)-1 or below -2^(DOUT_W-1) is clamped to that limit. The full-precision sum never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the input sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DIN_W | Signed input sample |
| out_valid | output | 1 | The M lanes carry a new output group |
| out_data | output | M*DOUT_W | M signed lanes, lane k at bits k*DOUT_W, lane 0 earliest in time |

## Verification
The assertions assume that in_valid and in_data are known at every rising edge once the internal reset has been released. The latency check also assumes that in_valid stays low during reset, so that the pipeline starts empty. The bench drives both inputs only at the falling edge and holds in_valid at 0 until the synchronised reset has gone high. It draws data from the full signed input range, and from a narrow range for the rounding phase. Gaps in in_valid are drawn at random, so every stretch of the valid pipeline appears. The saturation runs push a constant full-scale input through every lane and so drive the rounding path to both clamps.

// File: rtl/pinterp_pkg.sv
package pinterp_pkg;

  // number of prototype taps per polyphase branch after zero padding
  function automatic int taps_per_phase(input int ntaps, input int phases);
    return (ntaps + phases - 1) / phases;
  endfunction

  // width holding a sum of depth products without wrap
  function automatic int acc_width(input int din_w, input int coef_w, input int depth);
    return din_w + coef_w + $clog2(depth) + 1;
  endfunction

endpackage

// File: rtl/pinterp_rst_sync.sv
module pinterp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/pinterp_tapline.sv
module pinterp_tapline #(
  parameter int DIN_W = 12,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic [DIN_W-1:0]       din,
  output logic [DEPTH*DIN_W-1:0] taps_flat
);

  logic [DIN_W-1:0] stage_q [DEPTH];
  logic [DIN_W-1:0] stage_d [DEPTH];
  logic [DIN_W-1:0] src     [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign src[i] = din;
    end else begin : g_body
      assign src[i] = stage_q[i-1];
    end
    assign taps_flat[i*DIN_W +: DIN_W] = stage_q[i];
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      stage_d[i] = shift_en ? src[i] : stage_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= stage_d[i];
    end
  end

  // delay line is frozen on cycles without a sample
  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(taps_flat));

endmodule

// File: rtl/pinterp_lane.sv
module pinterp_lane
  import pinterp_pkg::*;
#(
  parameter int M      = 4,
  parameter int NTAPS  = 14,
  parameter int DEPTH  = 4,
  parameter int PHASE  = 0,
  parameter int DIN_W  = 12,
  parameter int COEF_W = 12,
  parameter int DOUT_W = 12,
  parameter int SHIFT  = 10,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_acc,
  input  logic                   ce_out,
  input  logic [DEPTH*DIN_W-1:0] taps_flat,
  output logic [DOUT_W-1:0]      lane_out
);

  localparam int PROD_W = DIN_W + COEF_W;
  localparam int ACC_W  = acc_width(DIN_W, COEF_W, DEPTH);
  localparam logic signed [ACC_W:0] BIAS =
    (SHIFT > 0) ? ((ACC_W+1)'(1) <<< (SHIFT > 0 ? SHIFT - 1 : 0)) : '0;
  localparam logic signed [ACC_W:0] HI =
    {{(ACC_W+2-DOUT_W){1'b0}}, {(DOUT_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] LO =
    {{(ACC_W+2-DOUT_W){1'b1}}, {(DOUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod [DEPTH];
  logic signed [ACC_W-1:0]  acc_sum, acc_d, acc_q;
  logic signed [ACC_W:0]    biased, shifted;
  logic signed [DOUT_W-1:0] sat_val, out_d, out_q;

  // one multiplier per live tap; padded taps build nothing
  for (genvar j = 0; j < DEPTH; j++) begin : g_tap
    localparam int IDX = PHASE + j * M;
    if (IDX < NTAPS) begin : g_live
      localparam logic signed [COEF_W-1:0] CF = COEFS[IDX*COEF_W +: COEF_W];
      logic signed [DIN_W-1:0] sample;
      assign sample  = taps_flat[j*DIN_W +: DIN_W];
      assign prod[j] = PROD_W'(sample) * PROD_W'(CF);
    end else begin : g_pad
      assign prod[j] = '0;
    end
  end

  always_comb begin
    acc_sum = '0;
    for (int j = 0; j < DEPTH; j++) begin
      acc_sum = acc_sum + ACC_W'(prod[j]);
    end
  end

  always_comb begin
    biased  = (ACC_W+1)'(acc_q) + BIAS;
    shifted = biased >>> SHIFT;
    if (shifted > HI) begin
      sat_val = HI[DOUT_W-1:0];
    end else if (shifted < LO) begin
      sat_val = LO[DOUT_W-1:0];
    end else begin
      sat_val = shifted[DOUT_W-1:0];
    end
  end

  always_comb begin
    acc_d = ce_acc ? acc_sum : acc_q;
    out_d = ce_out ? sat_val : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= '0;
    end else begin
      acc_q <= acc_d;
      out_q <= out_d;
    end
  end

  assign lane_out = out_q;

  // an all-zero delay line yields a zero sum
  assert_zero_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_acc && (taps_flat == '0)) |=> (acc_q == '0));

  // rounding and clamping never turn a non-negative sum negative
  assert_sign_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_out && !acc_q[ACC_W-1]) |=> !out_q[DOUT_W-1]);

endmodule

// File: rtl/polyphase_interp.sv
module polyphase_interp
  import pinterp_pkg::*;
#(
  parameter int M      = 4,
  parameter int NTAPS  = 14,
  parameter int DIN_W  = 12,
  parameter int COEF_W = 12,
  parameter int DOUT_W = 12,
  parameter int SHIFT  = 10,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = {
    -12'sd20, -12'sd60, 12'sd0, 12'sd210, 12'sd520, 12'sd830, 12'sd1000,
    12'sd1000, 12'sd830, 12'sd520, 12'sd210, 12'sd0, -12'sd60, -12'sd20}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DIN_W-1:0]      in_data,
  output logic                  out_valid,
  output logic [M*DOUT_W-1:0]   out_data
);

  localparam int DEPTH = taps_per_phase(NTAPS, M);

  logic                   rst_s_n;
  logic [DEPTH*DIN_W-1:0] taps_flat;
  logic                   v_tap_q, v_acc_q, v_out_q;
  logic                   v_tap_d, v_acc_d, v_out_d;

  pinterp_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  pinterp_tapline #(
    .DIN_W (DIN_W),
    .DEPTH (DEPTH)
  ) u_tapline (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .shift_en  (in_valid),
    .din       (in_data),
    .taps_flat (taps_flat)
  );

  for (genvar k = 0; k < M; k++) begin : g_lane
    pinterp_lane #(
      .M      (M),
      .NTAPS  (NTAPS),
      .DEPTH  (DEPTH),
      .PHASE  (k),
      .DIN_W  (DIN_W),
      .COEF_W (COEF_W),
      .DOUT_W (DOUT_W),
      .SHIFT  (SHIFT),
      .COEFS  (COEFS)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .ce_acc    (v_tap_q),
      .ce_out    (v_acc_q),
      .taps_flat (taps_flat),
      .lane_out  (out_data[k*DOUT_W +: DOUT_W])
    );
  end

  always_comb begin
    v_tap_d = in_valid;
    v_acc_d = v_tap_q;
    v_out_d = v_acc_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      v_tap_q <= 1'b0;
      v_acc_q <= 1'b0;
      v_out_q <= 1'b0;
    end else begin
      v_tap_q <= v_tap_d;
      v_acc_q <= v_acc_d;
      v_out_q <= v_out_d;
    end
  end

  assign out_valid = v_out_q;

  // edges seen since reset release, so the latency check looks back only that far
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !v_acc_q |=> $stable(out_data));

endmodule

// File: tb/polyphase_interp_tb_top.sv
module polyphase_interp_tb_top;

  localparam int M      = 4;
  localparam int NTAPS  = 14;
  localparam int DIN_W  = 12;
  localparam int COEF_W = 12;
  localparam int DOUT_W = 12;
  localparam int SHIFT  = 10;
  localparam int P      = (NTAPS + M - 1) / M;
  localparam int HT [NTAPS] = '{-20, -60, 0, 210, 520, 830, 1000,
                                1000, 830, 520, 210, 0, -60, -20};

  function automatic logic [NTAPS*COEF_W-1:0] pack_h();
    logic [NTAPS*COEF_W-1:0] v;
    v = '0;
    for (int i = 0; i < NTAPS; i++) v[i*COEF_W +: COEF_W] = COEF_W'(HT[i]);
    return v;
  endfunction
  localparam logic [NTAPS*COEF_W-1:0] HPACK = pack_h();

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [DIN_W-1:0] in_data;
  logic out_valid;
  logic [M*DOUT_W-1:0] out_data;

  always #5 clk = ~clk;

  polyphase_interp #(
    .M(M), .NTAPS(NTAPS), .DIN_W(DIN_W), .COEF_W(COEF_W),
    .DOUT_W(DOUT_W), .SHIFT(SHIFT), .COEFS(HPACK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    e_cnt = 0;
  bit    vin_r [8];
  string req_r [8];
  longint exp_r [8][M];
  longint hold [M];
  longint dl_m [P];

  function automatic longint coef(input int idx);
    return (idx < NTAPS) ? longint'(HT[idx]) : 64'sd0;
  endfunction

  function automatic longint rnd_sat(input longint acc);
    longint r;
    longint hi;
    longint lo;
    hi = (64'sd1 <<< (DOUT_W - 1)) - 1;
    lo = -(64'sd1 <<< (DOUT_W - 1));
    r  = acc + ((SHIFT > 0) ? (64'sd1 <<< (SHIFT > 0 ? SHIFT - 1 : 0)) : 64'sd0);
    r  = r >>> SHIFT;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  function automatic longint lane_val(input int k);
    return longint'($signed(out_data[k*DOUT_W +: DOUT_W]));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // one cycle: check outputs of the previous edge, then drive the next input
  task automatic step(input bit v, input int d, input string req);
    int ix;
    longint s;
    @(negedge clk);
    if (e_cnt >= 3) begin
      ix = (e_cnt - 3) % 8;
      if (vin_r[ix]) for (int k = 0; k < M; k++) hold[k] = exp_r[ix][k];
      chk(out_valid == vin_r[ix], "R2", "out_valid", longint'(out_valid), longint'(vin_r[ix]));
      for (int k = 0; k < M; k++)
        chk(lane_val(k) == hold[k], req_r[ix], $sformatf("lane%0d", k), lane_val(k), hold[k]);
    end
    in_valid = v;
    in_data  = DIN_W'(d);
    ix = e_cnt % 8;
    vin_r[ix] = v;
    req_r[ix] = req;
    if (v) begin
      for (int j = P - 1; j > 0; j--) dl_m[j] = dl_m[j-1];
      dl_m[0] = longint'(d);
      for (int k = 0; k < M; k++) begin
        s = 0;
        for (int j = 0; j < P; j++) s += coef(k + j * M) * dl_m[j];
        exp_r[ix][k] = rnd_sat(s);
      end
    end
    e_cnt++;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin
      vin_r[i] = 1'b0;
      req_r[i] = "R1";
      for (int k = 0; k < M; k++) exp_r[i][k] = 0;
    end
    for (int k = 0; k < M; k++) hold[k] = 0;
    for (int j = 0; j < P; j++) dl_m[j] = 0;

    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after release", longint'(out_valid), 0);
    for (int k = 0; k < M; k++)
      chk(lane_val(k) == 0, "R1", $sformatf("lane%0d after release", k), lane_val(k), 0);

    // impulse: lanes show taps in order, padded taps give zero (R5)
    step(1, 2047, "R5");
    for (int i = 0; i < P + 1; i++) step(1, 0, "R5");
    step(1, -2048, "R5");
    for (int i = 0; i < P + 1; i++) step(1, 0, "R5");

    // continuous random samples, full range (R3)
    for (int i = 0; i < 300; i++) step(1, int'($urandom_range(0, 4095)) - 2048, "R3");

    // random gaps in in_valid: no shift, outputs hold (R4)
    for (int i = 0; i < 300; i++)
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 4095)) - 2048, "R4");
    for (int i = 0; i < 6; i++) step(0, 1234, "R4");

    // small amplitudes exercise the half-step rounding (R6)
    for (int i = 0; i < 8; i++) begin
      step(1, (i % 2 == 0) ? 1 : -1, "R6");
      for (int j = 0; j < P; j++) step(1, 0, "R6");
    end
    for (int i = 0; i < 200; i++) step(1, int'($urandom_range(0, 8)) - 4, "R6");

    // full-scale constant input drives both clamps (R7)
    for (int i = 0; i < 12; i++) step(1, 2047, "R7");
    for (int i = 0; i < 12; i++) step(1, -2048, "R7");
    for (int i = 0; i < 12; i++) step(1, (i % 2 == 0) ? 2047 : -2048, "R7");

    for (int i = 0; i < 6; i++) step(0, 0, "R4");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule